// File: doc/BRIEF.md
# DMA Channel Register File with Byte Pointer

This block is the processor-facing register set of a four-channel DMA controller. A host reaches it through an 8-bit data port, a small register address, a chip select, and active-low read and write strobes. Each channel has a 16-bit start address and a 16-bit transfer count. Both are reached one byte at a time through a single toggling byte pointer. Each of them also has a working ("current") copy. The transfer engine loads its new values into the current copy as a transfer advances.

The block also holds the global command byte and a mode byte per channel. It holds the per-channel mask bits and the software request bits. It decodes two command-style writes: one clears the byte pointer and one performs a master clear. The host may change registers only while the transfer engine reports that it is idle or waiting for the bus grant. Reads are allowed at any time. Read data is registered and stays constant between reads.

Top module: `dma_cpu_regs`

## Requirements
- R1: An access happens once for each transition of its strobe from inactive to active while `cs_n` is low. A strobe held low for several cycles counts as one access. When both strobes are low, the write is performed and the read is ignored.
- R2: Channel n uses two register addresses. Address 2n selects its address register and address 2n+1 selects its count register, for n = 0..3.
- R3: A write to a channel slot stores the byte into both the start copy and the current copy of that register. A read of the slot returns a byte of the current copy.
- R4: The byte pointer is 0 (low byte) after reset. It toggles after every read or accepted write to addresses 0..7. A write to address 12 returns it to 0.
- R5: While `prog_ok_i` is low, every write is ignored, including clear commands, and the byte pointer does not move. Reads still work.
- R6: Mask bits are 1 (masked) after reset and after a master clear. A write to address 10 sets bit wdata[1:0] when wdata[2]=1 and clears it when wdata[2]=0. A write to address 15 loads all four bits from wdata[3:0].
- R7: A write to address 11 stores wdata into the mode byte of channel wdata[1:0]. Bits 7:6 select 00 demand, 01 single, 10 block, or 11 cascade. Cascade is flagged on `mode_bad_o`.
- R8: A write to address 9 sets request bit wdata[1:0] when wdata[2]=1, but only if that channel's mode bits 7:6 are 10 (block). With wdata[2]=0 it clears the bit.
- R9: A write to address 13 (master clear) clears the command byte, the request bits and the byte pointer, and sets all mask bits. The channel registers and mode bytes are kept.
- R10: A read of address 8 returns the command byte. Address 9 returns the request bits in bits 3:0, and address 10 returns the mask bits in bits 3:0. Addresses 11, 12, 13, 14 and 15 read as zero. `rdata_o` updates on the clock edge that detects the read and holds its value otherwise.
- R11: `cur_ld_i[n]` loads both current registers of channel n from `cur_addr_i` and `cur_cnt_i`. A host write to one of those registers in the same cycle takes precedence over the load for that register only. The start copies are never changed by a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| prog_ok_i | input | 1 | Engine idle or awaiting grant; writes allowed |
| cur_ld_i | input | 4 | Per-channel load of current registers from the engine |
| cur_addr_i | input | 16 | New current address from the engine |
| cur_cnt_i | input | 16 | New current count from the engine |
| rdata_o | output | 8 | Registered read data |
| base_addr_o | output | 64 | Start addresses, channel n at bits 16n+15:16n |
| cur_addr_o | output | 64 | Current addresses, same packing |
| base_cnt_o | output | 64 | Start counts, same packing |
| cur_cnt_o | output | 64 | Current counts, same packing |
| cmd_o | output | 8 | Command byte |
| mode_o | output | 32 | Mode bytes, channel n at bits 8n+7:8n |
| mask_o | output | 4 | Mask bits, 1 = masked |
| sreq_o | output | 4 | Software request bits |
| mode_bad_o | output | 4 | Channel mode is cascade (illegal) |

## Verification
The byte pointer is the one piece of hidden state. If it is wrong, every later 16-bit access lands on the wrong byte, and this shows at the next read of any channel slot. The bench therefore follows each write with reads of both bytes. It also checks the pointer again after clear commands, blocked writes and held strobes. A corrupted mask or request bit shows on the next read of address 9 or 10, and also at once on `mask_o` and `sreq_o`. A load from the engine that wrongly touches a start copy shows at once on `base_addr_o`.

// File: rtl/dma_cpu_regs_pkg.sv
package dma_cpu_regs_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'b00,
    XM_SINGLE  = 2'b01,
    XM_BLOCK   = 2'b10,
    XM_CASCADE = 2'b11
  } xfer_mode_e;

  // Offsets of control slots above the channel slots
  localparam int unsigned CTL_CMD    = 0;
  localparam int unsigned CTL_REQ    = 1;
  localparam int unsigned CTL_MSK1   = 2;
  localparam int unsigned CTL_MODE   = 3;
  localparam int unsigned CTL_CLRBP  = 4;
  localparam int unsigned CTL_MCLR   = 5;
  localparam int unsigned CTL_MSKALL = 7;

  typedef struct packed {
    logic cmd;
    logic req;
    logic msk1;
    logic mode;
    logic clrbp;
    logic mclr;
    logic mskall;
  } ctl_hit_t;

endpackage

// File: rtl/dma_cpu_regs_decode.sv
module dma_cpu_regs_decode
  import dma_cpu_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           rd_n,
  input  logic           wr_n,
  input  logic [AW-1:0]  addr,
  input  logic           prog_ok,
  output logic           wr_acc,
  output logic           rd_acc,
  output logic           slot_hit,
  output logic [CHW-1:0] slot_ch,
  output logic           slot_cnt,
  output ctl_hit_t       ctl
);

  localparam logic [AW-1:0] SLOTS = AW'(2 * NCH);

  logic          wr_act, rd_act;
  logic          wr_act_q, rd_act_q;
  logic [AW-1:0] offs;

  assign wr_act = ~cs_n & ~wr_n;
  assign rd_act = ~cs_n & ~rd_n & wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
    end
  end

  assign wr_acc = wr_act & ~wr_act_q & prog_ok;
  assign rd_acc = rd_act & ~rd_act_q;

  assign slot_hit = (addr < SLOTS);
  assign slot_ch  = addr[CHW:1];
  assign slot_cnt = addr[0];
  assign offs     = addr - SLOTS;

  always_comb begin
    ctl        = '0;
    ctl.cmd    = ~slot_hit & (offs == AW'(CTL_CMD));
    ctl.req    = ~slot_hit & (offs == AW'(CTL_REQ));
    ctl.msk1   = ~slot_hit & (offs == AW'(CTL_MSK1));
    ctl.mode   = ~slot_hit & (offs == AW'(CTL_MODE));
    ctl.clrbp  = ~slot_hit & (offs == AW'(CTL_CLRBP));
    ctl.mclr   = ~slot_hit & (offs == AW'(CTL_MCLR));
    ctl.mskall = ~slot_hit & (offs == AW'(CTL_MSKALL));
  end

  // R1: a held strobe yields a single access
  a_r1_wr_single: assert property (@(posedge clk) disable iff (rst)
    wr_acc |=> !wr_acc);
  a_r1_rd_single: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> !rd_acc);

endmodule

// File: rtl/dma_cpu_regs_chan.sv
module dma_cpu_regs_chan #(
  parameter int DW = 8,
  localparam int RW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_ok,
  input  logic          wr_a,
  input  logic          wr_c,
  input  logic          hi,
  input  logic [DW-1:0] wdata,
  input  logic          ld,
  input  logic [RW-1:0] ld_addr,
  input  logic [RW-1:0] ld_cnt,
  output logic [RW-1:0] base_a,
  output logic [RW-1:0] cur_a,
  output logic [RW-1:0] base_c,
  output logic [RW-1:0] cur_c
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_a <= '0;
      cur_a  <= '0;
    end else if (wr_a) begin
      if (hi) begin
        base_a[RW-1:DW] <= wdata;
        cur_a[RW-1:DW]  <= wdata;
      end else begin
        base_a[DW-1:0]  <= wdata;
        cur_a[DW-1:0]   <= wdata;
      end
    end else if (ld) begin
      cur_a <= ld_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_c <= '0;
      cur_c  <= '0;
    end else if (wr_c) begin
      if (hi) begin
        base_c[RW-1:DW] <= wdata;
        cur_c[RW-1:DW]  <= wdata;
      end else begin
        base_c[DW-1:0]  <= wdata;
        cur_c[DW-1:0]   <= wdata;
      end
    end else if (ld) begin
      cur_c <= ld_cnt;
    end
  end

  // R5: start copies only change when programming is allowed
  a_r5_base_a_locked: assert property (@(posedge clk) disable iff (rst)
    !$stable(base_a) |-> $past(prog_ok));
  a_r5_base_c_locked: assert property (@(posedge clk) disable iff (rst)
    !$stable(base_c) |-> $past(prog_ok));
  // R3: written byte lands in both copies
  a_r3_cur_lo_match: assert property (@(posedge clk) disable iff (rst)
    (wr_a && !hi) |=> cur_a[DW-1:0] == base_a[DW-1:0]);
  a_r3_cur_hi_match: assert property (@(posedge clk) disable iff (rst)
    (wr_c && hi) |=> cur_c[RW-1:DW] == base_c[RW-1:DW]);
  // R11: an engine load leaves the start copy alone
  a_r11_ld_keeps_base: assert property (@(posedge clk) disable iff (rst)
    (ld && !wr_a) |=> $stable(base_a));

endmodule

// File: rtl/dma_cpu_regs_ctrl.sv
module dma_cpu_regs_ctrl
  import dma_cpu_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_acc,
  input  ctl_hit_t          ctl,
  input  logic [DW-1:0]     wdata,
  input  logic              wide_acc,
  output logic [DW-1:0]     cmd,
  output logic [NCH*DW-1:0] mode_flat,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    sreq,
  output logic [NCH-1:0]    mode_bad,
  output logic              bptr
);

  logic [DW-1:0]  mode_q [NCH];
  logic [CHW-1:0] wsel;
  logic           wop;
  logic           sel_block;

  assign wsel      = wdata[CHW-1:0];
  assign wop       = wdata[CHW];
  assign sel_block = (mode_q[wsel][DW-1 -: 2] == XM_BLOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
    end else if (wr_acc && ctl.mclr) begin
      cmd <= '0;
    end else if (wr_acc && ctl.cmd) begin
      cmd <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
    end else if (wr_acc && ctl.mclr) begin
      mask <= '1;
    end else if (wr_acc && ctl.mskall) begin
      mask <= wdata[NCH-1:0];
    end else if (wr_acc && ctl.msk1) begin
      mask[wsel] <= wop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreq <= '0;
    end else if (wr_acc && ctl.mclr) begin
      sreq <= '0;
    end else if (wr_acc && ctl.req) begin
      if (!wop) begin
        sreq[wsel] <= 1'b0;
      end else if (sel_block) begin
        sreq[wsel] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bptr <= 1'b0;
    end else if (wr_acc && (ctl.clrbp || ctl.mclr)) begin
      bptr <= 1'b0;
    end else if (wide_acc) begin
      bptr <= ~bptr;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[i] <= '0;
      end else if (wr_acc && ctl.mode && (wsel == CHW'(i))) begin
        mode_q[i] <= wdata;
      end
    end
    assign mode_flat[i*DW +: DW] = mode_q[i];
    assign mode_bad[i] = (mode_q[i][DW-1 -: 2] == XM_CASCADE);

    // R8: a request bit can only rise on a block-mode channel
    a_r8_req_block: assert property (@(posedge clk) disable iff (rst)
      (!$past(sreq[i]) && sreq[i]) |-> $past(mode_q[i][DW-1 -: 2]) == XM_BLOCK);
  end

  // R6 / R9: master clear masks every channel and drops requests
  a_r6_mclr_masks: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && ctl.mclr) |=> (&mask) && (sreq == '0));
  // R4: pointer toggles on each channel-slot access
  a_r4_ptr_toggle: assert property (@(posedge clk) disable iff (rst)
    wide_acc |=> bptr != $past(bptr));
  // R4: pointer clear
  a_r4_ptr_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && ctl.clrbp) |=> !bptr);
  // R7: a cascade write raises the illegal flag
  a_r7_cascade_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && ctl.mode && wdata[DW-1 -: 2] == XM_CASCADE) |=> (|mode_bad));

endmodule

// File: rtl/dma_cpu_regs.sv
module dma_cpu_regs
  import dma_cpu_regs_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int RW  = 2 * DW,
  localparam int AW  = $clog2(2 * NCH) + 1,
  localparam int CHW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              prog_ok_i,
  input  logic [NCH-1:0]    cur_ld_i,
  input  logic [RW-1:0]     cur_addr_i,
  input  logic [RW-1:0]     cur_cnt_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NCH*RW-1:0] base_addr_o,
  output logic [NCH*RW-1:0] cur_addr_o,
  output logic [NCH*RW-1:0] base_cnt_o,
  output logic [NCH*RW-1:0] cur_cnt_o,
  output logic [DW-1:0]     cmd_o,
  output logic [NCH*DW-1:0] mode_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    sreq_o,
  output logic [NCH-1:0]    mode_bad_o
);

  logic           wr_acc, rd_acc, slot_hit, slot_cnt, wide_acc, bptr;
  logic [CHW-1:0] slot_ch;
  ctl_hit_t       ctl;
  logic [RW-1:0]  cur_a_w [NCH];
  logic [RW-1:0]  cur_c_w [NCH];
  logic [RW-1:0]  word;
  logic [DW-1:0]  rd_mux;
  logic           rd_void;

  dma_cpu_regs_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .addr     (addr_i),
    .prog_ok  (prog_ok_i),
    .wr_acc   (wr_acc),
    .rd_acc   (rd_acc),
    .slot_hit (slot_hit),
    .slot_ch  (slot_ch),
    .slot_cnt (slot_cnt),
    .ctl      (ctl)
  );

  assign wide_acc = (wr_acc | rd_acc) & slot_hit;

  dma_cpu_regs_ctrl #(.NCH(NCH), .DW(DW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_acc    (wr_acc),
    .ctl       (ctl),
    .wdata     (wdata_i),
    .wide_acc  (wide_acc),
    .cmd       (cmd_o),
    .mode_flat (mode_o),
    .mask      (mask_o),
    .sreq      (sreq_o),
    .mode_bad  (mode_bad_o),
    .bptr      (bptr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_i;
    assign hit_i = wr_acc & slot_hit & (slot_ch == CHW'(i));

    dma_cpu_regs_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .prog_ok (prog_ok_i),
      .wr_a    (hit_i & ~slot_cnt),
      .wr_c    (hit_i & slot_cnt),
      .hi      (bptr),
      .wdata   (wdata_i),
      .ld      (cur_ld_i[i]),
      .ld_addr (cur_addr_i),
      .ld_cnt  (cur_cnt_i),
      .base_a  (base_addr_o[i*RW +: RW]),
      .cur_a   (cur_a_w[i]),
      .base_c  (base_cnt_o[i*RW +: RW]),
      .cur_c   (cur_c_w[i])
    );

    assign cur_addr_o[i*RW +: RW] = cur_a_w[i];
    assign cur_cnt_o[i*RW +: RW]  = cur_c_w[i];
  end

  always_comb begin
    word   = slot_cnt ? cur_c_w[slot_ch] : cur_a_w[slot_ch];
    rd_mux = '0;
    if (slot_hit) begin
      rd_mux = bptr ? word[RW-1:DW] : word[DW-1:0];
    end else if (ctl.cmd) begin
      rd_mux = cmd_o;
    end else if (ctl.req) begin
      rd_mux = DW'(sreq_o);
    end else if (ctl.msk1) begin
      rd_mux = DW'(mask_o);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_acc) begin
      rdata_o <= rd_mux;
    end
  end

  assign rd_void = rd_acc & ~slot_hit & ~ctl.cmd & ~ctl.req & ~ctl.msk1;

  // R10: unmapped reads return zero, and data holds between reads
  a_r10_void_zero: assert property (@(posedge clk) disable iff (rst)
    rd_void |=> rdata_o == '0);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> $stable(rdata_o));
  // R10: a mask read reflects the mask bits
  a_r10_mask_read: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && ctl.msk1) |=> rdata_o == DW'($past(mask_o)));

endmodule

// File: tb/dma_cpu_regs_tb_top.sv
module dma_cpu_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        prog_ok = 1'b1;
  logic [3:0]  cur_ld = '0;
  logic [15:0] cur_addr = '0, cur_cnt = '0;
  logic [7:0]  rdata;
  logic [63:0] base_addr, cur_addr_w, base_cnt, cur_cnt_w;
  logic [7:0]  cmd;
  logic [31:0] mode;
  logic [3:0]  mask, sreq, mode_bad;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dma_cpu_regs dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr_i(addr), .wdata_i(wdata), .prog_ok_i(prog_ok),
    .cur_ld_i(cur_ld), .cur_addr_i(cur_addr), .cur_cnt_i(cur_cnt),
    .rdata_o(rdata), .base_addr_o(base_addr), .cur_addr_o(cur_addr_w),
    .base_cnt_o(base_cnt), .cur_cnt_o(cur_cnt_w), .cmd_o(cmd),
    .mode_o(mode), .mask_o(mask), .sreq_o(sreq), .mode_bad_o(mode_bad)
  );

  // {is_read, addr, wdata, expected read}
  localparam int NV = 33;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd12, 8'h00, 8'h00},
    {1'b0, 4'd0,  8'h34, 8'h00}, {1'b0, 4'd0, 8'h12, 8'h00},
    {1'b0, 4'd3,  8'hCD, 8'h00}, {1'b0, 4'd3, 8'hAB, 8'h00},
    {1'b1, 4'd0,  8'h00, 8'h34}, {1'b1, 4'd0, 8'h00, 8'h12},
    {1'b1, 4'd3,  8'h00, 8'hCD}, {1'b1, 4'd3, 8'h00, 8'hAB},
    {1'b0, 4'd6,  8'h78, 8'h00}, {1'b0, 4'd6, 8'h56, 8'h00},
    {1'b1, 4'd6,  8'h00, 8'h78}, {1'b1, 4'd6, 8'h00, 8'h56},
    {1'b0, 4'd11, 8'h82, 8'h00},
    {1'b0, 4'd9,  8'h06, 8'h00}, {1'b1, 4'd9, 8'h00, 8'h04},
    {1'b0, 4'd9,  8'h05, 8'h00}, {1'b1, 4'd9, 8'h00, 8'h04},
    {1'b0, 4'd9,  8'h02, 8'h00}, {1'b1, 4'd9, 8'h00, 8'h00},
    {1'b0, 4'd9,  8'h06, 8'h00}, {1'b1, 4'd9, 8'h00, 8'h04},
    {1'b0, 4'd15, 8'h05, 8'h00}, {1'b1, 4'd10, 8'h00, 8'h05},
    {1'b0, 4'd10, 8'h00, 8'h00}, {1'b1, 4'd10, 8'h00, 8'h04},
    {1'b0, 4'd10, 8'h07, 8'h00}, {1'b1, 4'd10, 8'h00, 8'h0C},
    {1'b0, 4'd8,  8'hA5, 8'h00}, {1'b1, 4'd8, 8'h00, 8'hA5},
    {1'b1, 4'd14, 8'h00, 8'h00},
    {1'b1, 4'd1,  8'h00, 8'h00}, {1'b1, 4'd1, 8'h00, 8'h00}
  };

  function automatic string tag_of(logic [3:0] a);
    if (a < 4'd8)        return "R2 R3 slot readback";
    else if (a == 4'd8)  return "R10 command read";
    else if (a == 4'd9)  return "R8 request";
    else if (a == 4'd10) return "R6 mask";
    else                 return "R10 unmapped";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    @(negedge clk);
    d = rdata;
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_chk(logic [3:0] a, logic [7:0] exp, string tag);
    logic [7:0] d;
    bus_rd(a, d);
    check(tag, 64'(d), 64'(exp));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    check("R10 rdata after reset", 64'(rdata), 64'h0);
    check("R6 mask after reset", 64'(mask), 64'hF);
    rd_chk(4'd10, 8'h0F, "R6 mask read after reset");
    rd_chk(4'd9, 8'h00, "R8 request after reset");

    // Vector walk (leaves byte pointer at low byte)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) rd_chk(VEC[i][19:16], VEC[i][7:0], tag_of(VEC[i][19:16]));
      else bus_wr(VEC[i][19:16], VEC[i][15:8]);
    end
    check("R2 ch1 count start copy", 64'(base_cnt[31:16]), 64'hABCD);
    check("R2 ch3 address start copy", 64'(base_addr[63:48]), 64'h5678);

    // R5: writes blocked while the engine is busy
    prog_ok = 1'b0;
    bus_wr(4'd0, 8'hFF);
    bus_wr(4'd13, 8'h00);
    rd_chk(4'd0, 8'h34, "R5 blocked write low byte");
    rd_chk(4'd0, 8'h12, "R5 pointer unmoved by blocked write");
    rd_chk(4'd10, 8'h0C, "R5 blocked master clear");

    // R11: engine load of current registers
    @(negedge clk);
    cur_ld = 4'b0001; cur_addr = 16'hBEEF; cur_cnt = 16'h0102;
    @(negedge clk);
    cur_ld = 4'b0000;
    check("R11 start address kept", 64'(base_addr[15:0]), 64'h1234);
    check("R11 current address loaded", 64'(cur_addr_w[15:0]), 64'hBEEF);
    rd_chk(4'd0, 8'hEF, "R11 read current addr lo");
    rd_chk(4'd0, 8'hBE, "R11 read current addr hi");
    rd_chk(4'd1, 8'h02, "R11 read current cnt lo");
    rd_chk(4'd1, 8'h01, "R11 read current cnt hi");

    // R4: clear pointer mid-pair
    prog_ok = 1'b1;
    rd_chk(4'd0, 8'hEF, "R4 first byte");
    bus_wr(4'd12, 8'h00);
    rd_chk(4'd0, 8'hEF, "R4 pointer cleared");

    // R9: master clear
    bus_wr(4'd13, 8'h00);
    rd_chk(4'd10, 8'h0F, "R9 mask set");
    rd_chk(4'd9, 8'h00, "R9 requests cleared");
    rd_chk(4'd8, 8'h00, "R9 command cleared");
    check("R9 mode kept", 64'(mode[23:16]), 64'h82);
    rd_chk(4'd0, 8'hEF, "R9 pointer cleared");

    // R7: cascade flagged illegal
    bus_wr(4'd11, 8'hC1);
    check("R7 cascade flag", 64'(mode_bad), 64'h2);

    // R1: held write strobe counts once
    bus_wr(4'd12, 8'h00);
    @(negedge clk);
    cs_n = 1'b0; addr = 4'd0; wdata = 8'h11; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    rd_chk(4'd0, 8'hBE, "R1 held strobe one toggle");
    rd_chk(4'd0, 8'h11, "R3 written low byte in current");

    // R1: both strobes low -> write only
    @(negedge clk);
    cs_n = 1'b0; addr = 4'd8; wdata = 8'h3C; wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    check("R1 read ignored during write", 64'(rdata), 64'h11);
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    rd_chk(4'd8, 8'h3C, "R1 write performed");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule